// File: doc/BRIEF.md
# Fixed-Length Readout Packet Builder

This block turns each triggered event of one front-end chip into a self-contained readout packet of fixed size and streams it out one byte per transfer. Every packet opens with a three-byte header that carries the packet kind, the L0 event identifier, an event counter and a four-bit error code. A five-byte hit payload follows and is zero-filled when the event holds fewer hits. A receiver can therefore decode any packet without looking at the packets of neighbouring chips.

Events come from the trigger and buffer logic through a single-cycle `evt_valid` strobe. They wait in a small first-in first-out queue until the byte sequencer is free to take them. The downstream link throttles the stream with an Xon/Xoff level, `xoff`. While it is high the byte on the output is frozen, so the timing between chips never has to be exact. If an event arrives while the queue is full, it is dropped and the drop is flagged in the error code of the next packet.

Top module: `pktb_builder`

## Requirements
- R1: While `rst_n` is low, and after its release until an event is accepted, `out_valid`, `out_sop` and `out_eop` are low.
- R2: Every packet is exactly 8 bytes long whatever its hit count; `out_sop` is high only on byte 0 and `out_eop` only on byte 7.
- R3: Header byte 0 is {kind[1:0] in bits 7:6, two zero bits in 5:4, error code in 3:0}, byte 1 is the L0 identifier and byte 2 is the event counter.
- R4: The 2-bit kind passes unchanged into bits 7:6 of byte 0, with the codes 0 = L0 data, 1 = L1 data, 2 = control data, 3 = monitoring (DCS) data.
- R5: Payload byte 3+k (k = 0..4) equals `evt_hits[8k+7:8k]` when k is below the hit count and zero otherwise; a hit count above 5 counts as 5.
- R6: A byte is transferred only in a cycle with `out_valid` high and `xoff` low; while `xoff` is high, `out_valid`, `out_data`, `out_sop` and `out_eop` hold, and after release the bytes continue with none lost or repeated.
- R7: An event accepted at a clock edge while nothing is queued or being sent shows its byte 0, with `out_sop`, right after the next edge.
- R8: When another event is queued as byte 7 transfers, the next packet's byte 0 is valid in the following cycle, with no idle cycle between packets.
- R9: The queue holds QDEPTH events besides the packet being sent; an event strobed while the queue is full is discarded and never emitted.
- R10: After a discard, bit 3 of the error code is forced to 1 in the first packet loaded after the discard, and in no later packet unless a further discard occurs.
- R11: Packets leave in the order their events were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe offering an event |
| evt_kind | input | 2 | Packet kind code |
| evt_l0id | input | 8 | L0 event identifier |
| evt_count | input | 8 | Event counter |
| evt_err | input | 4 | Error code from upstream |
| evt_nhits | input | NHIT_W (3) | Number of valid hit bytes |
| evt_hits | input | 8*PAY_BYTES (40) | Hit bytes, hit k in bits 8k+7:8k |
| xoff | input | 1 | Pause from the downstream link, high = hold |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |

## Verification
The hardest state to reach is a full queue with a discard, followed by a drain in which exactly one packet carries the forced error bit. From the ports this state exists only if the sequencer is blocked long enough for events to pile up. The stimulus therefore holds `xoff` high, strobes QDEPTH+2 events with known identifiers, then releases the pause. The bench checks that the first packet was already loaded before the discard and so shows a clean error code, that the second shows bit 3, and that the last event never appears. Pause holding is checked by raising `xoff` in the middle of a packet and comparing the frozen byte on every cycle.

// File: rtl/pktb_pkg.sv
package pktb_pkg;
   localparam int HDR_BYTES   = 3;
   localparam int ERR_W       = 4;
   localparam int OVF_ERR_BIT = 3;

   typedef enum logic [1:0] {
      PK_L0DATA = 2'd0,
      PK_L1DATA = 2'd1,
      PK_CTRL   = 2'd2,
      PK_MON    = 2'd3
   } pkt_kind_t;
endpackage

// File: rtl/pktb_evq.sv
module pktb_evq #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic             drop
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pktb_evq: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;
   logic             acc;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign acc   = push_req && !full;
   assign drop  = push_req && full;
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (acc) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (acc) wp <= wp + 1'b1;
         if (pop) rp <= rp + 1'b1;
         cnt <= cnt + {{AW{1'b0}}, acc} - {{AW{1'b0}}, pop};
      end
   end

   p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_full_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/pktb_frame.sv
module pktb_frame
   import pktb_pkg::*;
#(
   parameter int PAY_BYTES = 5,
   parameter int NHIT_W    = 3,
   localparam int NBYTES   = HDR_BYTES + PAY_BYTES
) (
   input  logic [1:0]             kind,
   input  logic [7:0]             l0id,
   input  logic [7:0]             evcnt,
   input  logic [ERR_W-1:0]       err,
   input  logic [NHIT_W-1:0]      nhits,
   input  logic [8*PAY_BYTES-1:0] hits,
   input  logic                   ovf,
   output logic [8*NBYTES-1:0]    frame
);
   logic [ERR_W-1:0]  err_eff;
   logic [NHIT_W-1:0] n_eff;

   always_comb begin
      err_eff              = err;
      err_eff[OVF_ERR_BIT] = err[OVF_ERR_BIT] | ovf;
   end

   assign n_eff = (nhits > NHIT_W'(PAY_BYTES)) ? NHIT_W'(PAY_BYTES) : nhits;

   assign frame[7:0]   = {kind, 2'b00, err_eff};
   assign frame[15:8]  = l0id;
   assign frame[23:16] = evcnt;

   for (genvar k = 0; k < PAY_BYTES; k++) begin : g_pay
      assign frame[8*(HDR_BYTES+k) +: 8] =
         (NHIT_W'(k) < n_eff) ? hits[8*k +: 8] : 8'h00;
   end
endmodule

// File: rtl/pktb_seq.sv
module pktb_seq #(
   parameter int NBYTES = 8,
   localparam int IW    = $clog2(NBYTES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [8*NBYTES-1:0] frame_in,
   input  logic                avail,
   input  logic                xoff,
   output logic                take,
   output logic                out_valid,
   output logic [7:0]          out_data,
   output logic                out_sop,
   output logic                out_eop
);
   logic [8*NBYTES-1:0] frame_q;
   logic [IW-1:0]       idx;
   logic                active, last, xfer;

   assign last = (idx == IW'(NBYTES - 1));
   assign xfer = active && !xoff;
   assign take = avail && (!active || (xfer && last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         idx     <= '0;
         frame_q <= '0;
      end else if (take) begin
         active  <= 1'b1;
         idx     <= '0;
         frame_q <= frame_in;
      end else if (xfer) begin
         if (last) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign out_valid = active;
   assign out_data  = frame_q[8*int'(idx) +: 8];
   assign out_sop   = active && (idx == '0);
   assign out_eop   = active && last;

   p_hold_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && xoff) |=> (out_valid && $stable(out_data)
                               && $stable(out_sop) && $stable(out_eop)));
   p_mid_packet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !xoff && !out_eop) |=> (out_valid && !out_sop));
   p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_eop && !xoff && avail) |=> out_sop);
endmodule

// File: rtl/pktb_builder.sv
module pktb_builder
   import pktb_pkg::*;
#(
   parameter int QDEPTH    = 4,
   parameter int PAY_BYTES = 5,
   localparam int NHIT_W   = $clog2(PAY_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   evt_valid,
   input  logic [1:0]             evt_kind,
   input  logic [7:0]             evt_l0id,
   input  logic [7:0]             evt_count,
   input  logic [3:0]             evt_err,
   input  logic [NHIT_W-1:0]      evt_nhits,
   input  logic [8*PAY_BYTES-1:0] evt_hits,
   input  logic                   xoff,
   output logic                   out_valid,
   output logic [7:0]             out_data,
   output logic                   out_sop,
   output logic                   out_eop
);
   localparam int NBYTES = HDR_BYTES + PAY_BYTES;
   localparam int EVW    = 2 + 8 + 8 + ERR_W + NHIT_W + 8*PAY_BYTES;

   if (PAY_BYTES < 1) begin : g_bad_pay
      $error("pktb_builder: PAY_BYTES must be at least 1");
   end

   logic [EVW-1:0]      q_in, q_out;
   logic                q_empty, q_full, q_drop, take, ovf_q;
   logic [8*NBYTES-1:0] frame;

   assign q_in = {evt_kind, evt_l0id, evt_count, evt_err, evt_nhits, evt_hits};

   pktb_evq #(.WIDTH(EVW), .DEPTH(QDEPTH)) u_evq (
      .clk(clk), .rst_n(rst_n), .push_req(evt_valid), .din(q_in),
      .pop(take), .dout(q_out), .empty(q_empty), .full(q_full), .drop(q_drop)
   );

   pktb_frame #(.PAY_BYTES(PAY_BYTES), .NHIT_W(NHIT_W)) u_frame (
      .kind (q_out[EVW-1 -: 2]),
      .l0id (q_out[EVW-3 -: 8]),
      .evcnt(q_out[EVW-11 -: 8]),
      .err  (q_out[EVW-19 -: ERR_W]),
      .nhits(q_out[8*PAY_BYTES +: NHIT_W]),
      .hits (q_out[8*PAY_BYTES-1:0]),
      .ovf  (ovf_q),
      .frame(frame)
   );

   pktb_seq #(.NBYTES(NBYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_in(frame), .avail(!q_empty),
      .xoff(xoff), .take(take), .out_valid(out_valid), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop)
   );

   // A discard in the same cycle as a load flags the following packet.
   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= q_drop | (ovf_q & ~take);
   end

   p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && q_full) |=> ovf_q);
   p_ovf_in_header_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ovf_q) |=> (out_sop && out_data[OVF_ERR_BIT]));
   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> (out_data[5:4] == 2'b00));
endmodule

// File: tb/pktb_builder_tb.sv
module pktb_builder_tb;
   localparam int QD   = 4;
   localparam int NVEC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [1:0]  evt_kind = '0;
   logic [7:0]  evt_l0id = '0;
   logic [7:0]  evt_count = '0;
   logic [3:0]  evt_err = '0;
   logic [2:0]  evt_nhits = '0;
   logic [39:0] evt_hits = '0;
   logic        xoff = 1'b0;
   logic        out_valid, out_sop, out_eop;
   logic [7:0]  out_data;

   always #2 clk = ~clk;

   pktb_builder #(.QDEPTH(QD), .PAY_BYTES(5)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
      .evt_l0id(evt_l0id), .evt_count(evt_count), .evt_err(evt_err),
      .evt_nhits(evt_nhits), .evt_hits(evt_hits), .xoff(xoff),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop)
   );

   // {kind, l0id, count, err, nhits, hits}
   localparam logic [64:0] VEC [NVEC] = '{
      {2'd0, 8'h11, 8'h01, 4'h0, 3'd5, 40'h5544332211},
      {2'd1, 8'hA5, 8'h02, 4'h3, 3'd0, 40'hFFFFFFFFFF},
      {2'd2, 8'h3C, 8'h03, 4'h7, 3'd2, 40'h99887766BB},
      {2'd3, 8'hFF, 8'hFE, 4'hF, 3'd7, 40'h0102030405},
      {2'd1, 8'h00, 8'h80, 4'h8, 3'd4, 40'hDEADBEEF42},
      {2'd0, 8'h7E, 8'h7F, 4'h1, 3'd1, 40'hCAFEF00D99}
   };

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int ncap   = 0;
   logic [7:0] cap_data [512];
   logic       cap_sop  [512];
   logic       cap_eop  [512];
   int         cap_cyc  [512];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid && !xoff && ncap < 512) begin
         cap_data[ncap] = out_data;
         cap_sop[ncap]  = out_sop;
         cap_eop[ncap]  = out_eop;
         cap_cyc[ncap]  = cyc;
         ncap = ncap + 1;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [64:0] ev, input int i, input logic ovf);
      logic [3:0] e;
      int n;
      e = ev[46:43];
      if (ovf) e[3] = 1'b1;
      n = (int'(ev[42:40]) > 5) ? 5 : int'(ev[42:40]);
      if (i == 0) return {ev[64:63], 2'b00, e};
      if (i == 1) return ev[62:55];
      if (i == 2) return ev[54:47];
      if (i - 3 < n) return ev[8*(i-3) +: 8];
      return 8'h00;
   endfunction

   task automatic send(input logic [64:0] ev);
      @(posedge clk); #1;
      {evt_kind, evt_l0id, evt_count, evt_err, evt_nhits, evt_hits} = ev;
      evt_valid = 1'b1;
      @(posedge clk); #1;
      evt_valid = 1'b0;
   endtask

   task automatic wait_cap(input int target);
      while (ncap < target) @(negedge clk);
   endtask

   task automatic check_pkt(input int start, input logic [64:0] ev, input logic ovf, input string tag);
      for (int i = 0; i < 8; i++) begin
         chk(cap_data[start+i] == exp_byte(ev, i, ovf), tag,
             cap_data[start+i], exp_byte(ev, i, ovf));
         chk(cap_sop[start+i] == (i == 0), {tag, " R2 sop"}, cap_sop[start+i], i == 0);
         chk(cap_eop[start+i] == (i == 7), {tag, " R2 eop"}, cap_eop[start+i], i == 7);
      end
   endtask

   initial begin
      int base;
      logic [64:0] ev;
      logic [7:0]  held;

      // R1: outputs idle in and after reset
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_sop && !out_eop, "R1 in reset", out_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_sop && !out_eop, "R1 after reset", out_valid, 0);

      // R2 R3 R4 R5: table of events, one packet each
      for (int v = 0; v < NVEC; v++) begin
         base = ncap;
         send(VEC[v]);
         wait_cap(base + 8);
         repeat (2) @(negedge clk);
         chk(ncap == base + 8, "R2 length", ncap - base, 8);
         check_pkt(base, VEC[v], 1'b0, "R3 R4 R5 table");
      end

      // R7: latency from an idle state
      repeat (3) @(negedge clk);
      @(posedge clk); #1;
      {evt_kind, evt_l0id, evt_count, evt_err, evt_nhits, evt_hits} = VEC[0];
      evt_valid = 1'b1;
      @(negedge clk);
      @(posedge clk); #1 evt_valid = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 not before load", out_valid, 0);
      @(negedge clk);
      chk(out_valid && out_sop && out_data == exp_byte(VEC[0], 0, 1'b0),
          "R7 first byte", out_data, exp_byte(VEC[0], 0, 1'b0));
      wait_cap(ncap + 7);
      repeat (3) @(negedge clk);

      // R6: pause in the middle of a packet
      base = ncap;
      send(VEC[2]);
      wait_cap(base + 3);
      @(posedge clk); #1 xoff = 1'b1;
      @(negedge clk);
      held = out_data;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk(out_valid && out_data == held && !out_sop, "R6 held byte", out_data, held);
      end
      chk(held == exp_byte(VEC[2], ncap - base, 1'b0), "R6 held value",
          held, exp_byte(VEC[2], ncap - base, 1'b0));
      @(posedge clk); #1 xoff = 1'b0;
      wait_cap(base + 8);
      repeat (3) @(negedge clk);
      chk(ncap == base + 8, "R6 no loss or repeat", ncap - base, 8);
      check_pkt(base, VEC[2], 1'b0, "R6 resumed packet");

      // R8 R11: two queued events leave back to back in order
      base = ncap;
      @(posedge clk); #1 xoff = 1'b1;
      send(VEC[4]);
      send(VEC[5]);
      @(posedge clk); #1 xoff = 1'b0;
      wait_cap(base + 16);
      repeat (3) @(negedge clk);
      check_pkt(base, VEC[4], 1'b0, "R11 first");
      check_pkt(base + 8, VEC[5], 1'b0, "R11 second");
      chk(cap_cyc[base+8] == cap_cyc[base+7] + 1, "R8 no gap",
          cap_cyc[base+8] - cap_cyc[base+7], 1);

      // R9 R10: fill the queue while paused, one event discarded
      base = ncap;
      @(posedge clk); #1 xoff = 1'b1;
      for (int e = 0; e < QD + 2; e++) begin
         ev = {2'd1, 8'(8'h40 + e), 8'(e), 4'h0, 3'd3, 40'h0000ABCDEF};
         send(ev);
      end
      @(posedge clk); #1 xoff = 1'b0;
      wait_cap(base + 8*(QD+1));
      repeat (30) @(negedge clk);
      chk(ncap == base + 8*(QD+1), "R9 discard count", (ncap - base) / 8, QD + 1);
      for (int e = 0; e < QD + 1; e++) begin
         ev = {2'd1, 8'(8'h40 + e), 8'(e), 4'h0, 3'd3, 40'h0000ABCDEF};
         check_pkt(base + 8*e, ev, (e == 1), "R9 R10 overflow drain");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule